// File: doc/BRIEF.md
# Fractional Reference Clock Divider

This block derives a reference clock from one of sixteen parent clock levels. The parent levels are sampled in the system clock domain. It divides the selected parent by twice a 15-bit integer divisor plus a 9-bit fraction in steps of 1/512. The output frequency is fin / (2 × (div + trim/512)). A divisor of zero passes the selected parent straight through. The fraction comes from a 9-bit accumulator. The trim value is added to it at the end of every half-period, and each carry out lengthens the next half-period by one parent cycle.

Software drives the block through a plain write port with two words. The control word holds the source select, a read-only running flag, a self-clearing apply bit, an output gate, a module enable and the integer divisor. The trim word holds the fraction. A new divisor or trim written to these words is only pending. It reaches the divider through the apply handshake: the apply bit stays set until the divider has taken the values, then clears by itself. Both words read back continuously. There is no stream traffic, so every pin is a plain control or status pin.

Top module: `refclk_gen`

## Requirements
- R1: After reset both readback words are zero and `ref_out` is low.
- R2: With trim 0 and divisor D ≥ 1, `ref_out` has a period of exactly 2·D cycles of the selected parent.
- R3: With an applied divisor of 0, `ref_out` follows the selected parent level (one system cycle late), so its period equals the parent's.
- R4: With trim T, each half-period lasts D parent cycles plus one extra cycle whenever the 9-bit sum of accumulator and T carries. With T=256 every full period is 2·D+1 parent cycles. With T=128, four full periods total 8·D+2 parent cycles.
- R5: A divisor written in control bits 30:16, or a trim written in trim bits 31:23, without control bit 9 set does not change the output period. The divisor field reads back the pending value.
- R6: Writing control bit 9 as 1 sets it. It reads 1 until the divider takes the pending values at the next rising edge of the selected parent (or one cycle later when the module is off), then reads 0.
- R7: The source select, control bits 3:0, is updated by a write only while the running flag (bit 8) is clear. Otherwise the old select is kept.
- R8: The running flag reads 1 from the second cycle after the enable (bit 15) is set. After the enable is cleared it stays 1 for OFF_DLY more cycles and reads 0 from cycle OFF_DLY+1.
- R9: With the output gate (bit 12) at 0, `ref_out` is held low.
- R10: With the enable (bit 15) at 0, `ref_out` is low and the divider is held at its start state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_clk | input | 16 | Parent clock levels, one per selectable source |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 writes the control word, 1 the trim word |
| wr_data | input | 32 | Write data |
| ctrl_q | output | 32 | Control word readback |
| trim_q | output | 32 | Trim word readback |
| ref_out | output | 1 | Divided reference clock |

## Verification
A write is registered at the clock edge where the strobe is high. Readback fields are therefore due by the following falling edge, except the running flag, which trails the enable by one more register and by OFF_DLY+1 cycles on the way down. The bench samples all outputs on falling edges and checks those flags exactly at the cycles the requirements name. Divider results settle only after the first half-period following an apply. The bench therefore skips two rising edges of `ref_out` and then measures whole periods, or sums of four periods for fractional trims. This makes the expected counts independent of where the apply landed in the parent's phase.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int SEL_LSB   = 0;
  localparam int SEL_W     = 4;
  localparam int RUN_BIT   = 8;
  localparam int APPLY_BIT = 9;
  localparam int GATE_BIT  = 12;
  localparam int EN_BIT    = 15;
  localparam int DIV_LSB   = 16;
  localparam int DIV_W     = 15;
  localparam int FRAC_LSB  = 23;
  localparam int FRAC_W    = 9;
  localparam int WORD_W    = 32;
endpackage

// File: rtl/refclk_regs.sv
module refclk_regs
  import refclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              running,
  input  logic              taken,
  output logic [SEL_W-1:0]  sel,
  output logic              en,
  output logic              gate,
  output logic              apply_req,
  output logic [DIV_W-1:0]  div_pend,
  output logic [FRAC_W-1:0] frac_pend
);
  logic wr_ctrl, wr_frac;
  assign wr_ctrl = wr_en && !wr_sel;
  assign wr_frac = wr_en && wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel       <= '0;
      en        <= 1'b0;
      gate      <= 1'b0;
      apply_req <= 1'b0;
      div_pend  <= '0;
      frac_pend <= '0;
    end else begin
      if (wr_ctrl) begin
        en       <= wr_data[EN_BIT];
        gate     <= wr_data[GATE_BIT];
        div_pend <= wr_data[DIV_LSB +: DIV_W];
        if (!running) sel <= wr_data[SEL_LSB +: SEL_W];
      end
      if (wr_frac) frac_pend <= wr_data[FRAC_LSB +: FRAC_W];
      if (wr_ctrl && wr_data[APPLY_BIT]) apply_req <= 1'b1;
      else if (taken)                    apply_req <= 1'b0;
    end
  end
endmodule

// File: rtl/refclk_activity.sv
module refclk_activity #(
  parameter int OFF_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic running
);
  localparam int CNT_W = $clog2(OFF_DLY + 1);
  logic [CNT_W-1:0] drain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain   <= '0;
      running <= 1'b0;
    end else begin
      running <= en || (drain != '0);
      if (en)                drain <= CNT_W'(OFF_DLY);
      else if (drain != '0)  drain <= drain - 1'b1;
    end
  end
endmodule

// File: rtl/refclk_frac_div.sv
module refclk_frac_div
  import refclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              src_lvl,
  input  logic              apply_req,
  input  logic [DIV_W-1:0]  div_pend,
  input  logic [FRAC_W-1:0] frac_pend,
  output logic              taken,
  output logic              ref_lvl
);
  localparam int CNT_W = DIV_W + 1;

  logic              s_q, s_d, rise;
  logic [DIV_W-1:0]  div_act;
  logic [FRAC_W-1:0] frac_act, acc;
  logic              ext;
  logic              tog;
  logic [CNT_W-1:0]  cnt, last;
  logic [FRAC_W:0]   sum;

  assign rise  = s_q && !s_d;
  assign taken = apply_req && (rise || !en);
  assign last  = {1'b0, div_act} + CNT_W'(ext) - 1'b1;
  assign sum   = {1'b0, acc} + {1'b0, frac_act};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= 1'b0;
      s_d <= 1'b0;
    end else begin
      s_q <= src_lvl;
      s_d <= s_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_act  <= '0;
      frac_act <= '0;
    end else if (taken) begin
      div_act  <= div_pend;
      frac_act <= frac_pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
      ext <= 1'b0;
      tog <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      acc <= '0;
      ext <= 1'b0;
      tog <= 1'b0;
    end else if (taken) begin
      cnt <= '0;
      acc <= '0;
      ext <= 1'b0;
    end else if (rise && div_act != '0) begin
      if (cnt == last) begin
        cnt <= '0;
        tog <= !tog;
        acc <= sum[FRAC_W-1:0];
        ext <= sum[FRAC_W];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign ref_lvl = (div_act == '0) ? s_q : tog;
endmodule

// File: rtl/refclk_gen.sv
module refclk_gen
  import refclk_pkg::*;
#(
  parameter int NSRC    = 16,
  parameter int OFF_DLY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_clk,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] trim_q,
  output logic              ref_out
);
  logic [SEL_W-1:0]  sel;
  logic              en, gate, apply_req, running, taken, ref_lvl, src_lvl;
  logic [DIV_W-1:0]  div_pend;
  logic [FRAC_W-1:0] frac_pend;
  logic [(1<<SEL_W)-1:0] src_pad;

  generate
    if (NSRC >= (1 << SEL_W)) begin : g_full
      assign src_pad = src_clk[(1<<SEL_W)-1:0];
    end else begin : g_pad
      assign src_pad = {{((1<<SEL_W)-NSRC){1'b0}}, src_clk};
    end
  endgenerate

  assign src_lvl = src_pad[sel];

  refclk_regs u_regs (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data,
    .running, .taken,
    .sel, .en, .gate, .apply_req, .div_pend, .frac_pend
  );

  refclk_activity #(.OFF_DLY(OFF_DLY)) u_act (
    .clk, .rst_n, .en, .running
  );

  refclk_frac_div u_div (
    .clk, .rst_n, .en, .src_lvl, .apply_req, .div_pend, .frac_pend,
    .taken, .ref_lvl
  );

  always_comb begin
    ctrl_q = '0;
    ctrl_q[SEL_LSB +: SEL_W] = sel;
    ctrl_q[RUN_BIT]          = running;
    ctrl_q[APPLY_BIT]        = apply_req;
    ctrl_q[GATE_BIT]         = gate;
    ctrl_q[EN_BIT]           = en;
    ctrl_q[DIV_LSB +: DIV_W] = div_pend;
    trim_q = '0;
    trim_q[FRAC_LSB +: FRAC_W] = frac_pend;
  end

  assign ref_out = en && gate && ref_lvl;
endmodule

// File: rtl/refclk_gen_chk.sv
module refclk_gen_chk
  import refclk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [WORD_W-1:0] ctrl_q,
  input logic              ref_out
);
  a_r7_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[RUN_BIT] |=> ctrl_q[SEL_LSB +: SEL_W] == $past(ctrl_q[SEL_LSB +: SEL_W]));

  a_r8_run_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[EN_BIT] |=> ctrl_q[RUN_BIT]);

  a_r9_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[GATE_BIT] |-> !ref_out);

  a_r10_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[EN_BIT] |-> !ref_out);

  a_r6_apply_clears_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[APPLY_BIT] && !ctrl_q[EN_BIT] && !(wr_en && !wr_sel)) |=> !ctrl_q[APPLY_BIT]);
endmodule

bind refclk_gen refclk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .ctrl_q(ctrl_q), .ref_out(ref_out)
);

// File: tb/refclk_gen_tb.sv
module refclk_gen_tb;
  localparam int OFF_DLY = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_clk;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl_q, trim_q;
  logic        ref_out;
  logic [15:0] free_cnt = '0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;
  always @(negedge clk) free_cnt <= free_cnt + 1'b1;
  assign src_clk = free_cnt;

  refclk_gen #(.NSRC(16), .OFF_DLY(OFF_DLY)) u_dut (
    .clk, .rst_n, .src_clk, .wr_en, .wr_sel, .wr_data,
    .ctrl_q, .trim_q, .ref_out
  );

  function automatic logic [31:0] mk_ctrl(input logic [3:0] sel, input logic apply,
                                          input logic gate, input logic en,
                                          input logic [14:0] div);
    logic [31:0] w;
    w = '0;
    w[3:0] = sel; w[9] = apply; w[12] = gate; w[15] = en; w[30:16] = div;
    return w;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel_t, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel_t; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(output bit ok);
    logic prev;
    ok = 1'b0;
    prev = ref_out;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!prev && ref_out) begin ok = 1'b1; break; end
      prev = ref_out;
    end
  endtask

  task automatic measure(input int n, output int cyc);
    bit ok;
    cyc = 0;
    wait_rise(ok); wait_rise(ok);
    for (int p = 0; p < n; p++) begin
      logic prev;
      prev = ref_out;
      ok = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        @(negedge clk);
        cyc++;
        if (!prev && ref_out) begin ok = 1'b1; break; end
        prev = ref_out;
      end
      if (!ok) begin cyc = -1; return; end
    end
  endtask

  task automatic configure(input logic [3:0] sel, input logic [14:0] div, input logic [8:0] tr);
    wr(1'b0, mk_ctrl(sel, 1'b0, 1'b0, 1'b0, div));
    repeat (OFF_DLY + 3) @(negedge clk);
    wr(1'b1, {tr, 23'b0});
    wr(1'b0, mk_ctrl(sel, 1'b1, 1'b0, 1'b0, div));
    @(negedge clk);
    wr(1'b0, mk_ctrl(sel, 1'b0, 1'b1, 1'b1, div));
  endtask

  task automatic t_reset;
    chk("R1 ctrl", int'(ctrl_q), 0);
    chk("R1 trim", int'(trim_q), 0);
    chk("R1 ref_out", int'(ref_out), 0);
  endtask

  task automatic t_integer;
    int c;
    configure(4'd1, 15'd3, 9'd0);
    measure(1, c); chk("R2 div3 src1", c, 24);
    configure(4'd1, 15'd1, 9'd0);
    measure(1, c); chk("R2 div1 src1", c, 8);
  endtask

  task automatic t_pass;
    int c;
    configure(4'd2, 15'd0, 9'd0);
    measure(1, c); chk("R3 passthrough src2", c, 8);
  endtask

  task automatic t_frac;
    int c;
    configure(4'd1, 15'd3, 9'd256);
    measure(1, c); chk("R4 trim256", c, 28);
    configure(4'd1, 15'd3, 9'd128);
    measure(4, c); chk("R4 trim128 4 periods", c, 104);
  endtask

  task automatic t_pending;
    int c;
    configure(4'd1, 15'd3, 9'd0);
    wr(1'b0, mk_ctrl(4'd1, 1'b0, 1'b1, 1'b1, 15'd5));
    wr(1'b1, {9'd256, 23'b0});
    chk("R5 div readback", int'(ctrl_q[30:16]), 5);
    measure(1, c); chk("R5 no apply keeps period", c, 24);
    wr(1'b0, mk_ctrl(4'd1, 1'b1, 1'b1, 1'b1, 15'd5));
    chk("R6 apply set", int'(ctrl_q[9]), 1);
    repeat (12) @(negedge clk);
    chk("R6 apply cleared", int'(ctrl_q[9]), 0);
    measure(1, c); chk("R5 applied div5 trim256", c, 44);
  endtask

  task automatic t_sel_lock;
    int c;
    configure(4'd1, 15'd2, 9'd0);
    wr(1'b0, mk_ctrl(4'd2, 1'b0, 1'b1, 1'b1, 15'd2));
    chk("R7 sel kept while running", int'(ctrl_q[3:0]), 1);
    measure(1, c); chk("R7 period unchanged", c, 16);
    configure(4'd2, 15'd2, 9'd0);
    chk("R7 sel taken when idle", int'(ctrl_q[3:0]), 2);
    measure(1, c); chk("R7 new source period", c, 32);
  endtask

  task automatic t_active;
    wr(1'b0, mk_ctrl(4'd1, 1'b0, 1'b0, 1'b0, 15'd2));
    repeat (OFF_DLY + 3) @(negedge clk);
    chk("R8 idle flag", int'(ctrl_q[8]), 0);
    wr(1'b0, mk_ctrl(4'd1, 1'b0, 1'b1, 1'b1, 15'd2));
    chk("R8 flag one cycle after enable", int'(ctrl_q[8]), 0);
    @(negedge clk);
    chk("R8 flag set", int'(ctrl_q[8]), 1);
    wr(1'b0, mk_ctrl(4'd1, 1'b0, 1'b1, 1'b0, 15'd2));
    repeat (OFF_DLY) @(negedge clk);
    chk("R8 flag held during drain", int'(ctrl_q[8]), 1);
    @(negedge clk);
    chk("R8 flag cleared", int'(ctrl_q[8]), 0);
  endtask

  task automatic t_gates;
    int highs;
    configure(4'd1, 15'd1, 9'd0);
    wr(1'b0, mk_ctrl(4'd1, 1'b0, 1'b0, 1'b1, 15'd1));
    highs = 0;
    for (int i = 0; i < 64; i++) begin @(negedge clk); if (ref_out) highs++; end
    chk("R9 gate low", highs, 0);
    wr(1'b0, mk_ctrl(4'd1, 1'b0, 1'b1, 1'b0, 15'd1));
    highs = 0;
    for (int i = 0; i < 64; i++) begin @(negedge clk); if (ref_out) highs++; end
    chk("R10 disabled low", highs, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_integer;
    t_pass;
    t_frac;
    t_pending;
    t_sel_lock;
    t_active;
    t_gates;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule